// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Pulse Output

A 16-bit timer/counter run by an 8-bit control word. It counts internal ticks or falling edges on an external count pin. A single strobe pin has several uses. It can capture the count into a shared capture/reload register. It can force a reload from that register. When the direction option is on, its level steers the count up or down. Overflow can reload the count, set a sticky flag, raise an interrupt, toggle a clock output, or emit separate receive and transmit baud pulses for a serial port.

The mode comes from the control word together with two static option inputs: one enables up/down counting and one enables the clock output. Software loads the control word, the count and the capture/reload register through three separate write strobes. Register addressing, pin multiplexing and the serial port itself live outside this block.

Top module: `crt_timer`

## Requirements
- R1: After reset the control word, count, capture/reload register, interrupt, baud pulses and clock output are all 0.
- R2: The control word is laid out as bit 7 overflow flag, bit 6 strobe flag, bit 5 receive-baud select, bit 4 transmit-baud select, bit 3 strobe enable, bit 2 run, bit 1 source select, bit 0 capture select. With run at 0 the count holds. With source select at 0 the count advances on each cycle with `tick_en` high. With source select at 1 it advances once for each falling edge on `cnt_pin`, seen as 1 then 0 on two consecutive samples.
- R3: In reload mode (capture select 0, both baud selects 0, up/down option off) the count goes from 0xFFFF to the capture/reload register on a step, and the overflow flag is set in the same cycle.
- R4: In capture mode (capture select 1) an overflow wraps the count to 0 and sets the overflow flag. With strobe enable at 1, a falling strobe edge copies the count into the capture/reload register and sets the strobe flag. With strobe enable at 0, strobe edges change neither.
- R5: In reload mode with strobe enable at 1, a falling strobe edge loads the count from the capture/reload register and sets the strobe flag.
- R6: With either baud select at 1, capture select is ignored. Overflow reloads the count and does not set the overflow flag. It produces a one-cycle high pulse on `rx_baud` (if bit 5) and/or `tx_baud` (if bit 4), registered on the same clock edge as the overflow.
- R7: With `updown_en` at 1 and no capture or baud select, a synchronized strobe level of 1 counts up and 0 counts down. A down step taken while the count equals the capture/reload register loads 0xFFFF and sets the overflow flag. Strobe edges then only set the strobe flag.
- R8: `irq` is high whenever the overflow flag is set, or the strobe flag is set while the up/down mode is not active.
- R9: Flags are cleared only by a control write. A hardware flag set in the same cycle as a control write wins. A software count write in the same cycle as a step wins.
- R10: With `clkout_en` at 1, source select 0 and no baud select, each overflow reloads the count and toggles `clk_out`, and the overflow flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Internal count tick |
| cnt_pin | input | 1 | External event pin |
| stb_pin | input | 1 | Strobe / direction pin |
| updown_en | input | 1 | Up/down counting option |
| clkout_en | input | 1 | Clock output option |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| rc_we | input | 1 | Capture/reload register write strobe |
| rc_wdata | input | 16 | Capture/reload register write data |
| ctl_q | output | 8 | Control word |
| count_q | output | 16 | Current count |
| rc_q | output | 16 | Capture/reload register |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| ext_flag | output | 1 | Strobe flag (control bit 6) |
| irq | output | 1 | Interrupt request |
| rx_baud | output | 1 | Receive baud pulse |
| tx_baud | output | 1 | Transmit baud pulse |
| clk_out | output | 1 | Toggled clock output |

## Verification
A hardware flag set can land in the same cycle as a software control write that clears the flags, and a counting step can land in the same cycle as a software count write. The bench forces both collisions by raising `tick_en` on a count of 0xFFFF together with `ctl_we` (flag data 0), and then `tick_en` together with `cnt_we`. It judges them from the overflow flag staying at 1 and from the count equalling the written value rather than the incremented one.

// File: rtl/crt_pkg.sv
package crt_pkg;
   localparam int B_OVF  = 7;
   localparam int B_EXT  = 6;
   localparam int B_RXS  = 5;
   localparam int B_TXS  = 4;
   localparam int B_EXEN = 3;
   localparam int B_RUN  = 2;
   localparam int B_SRC  = 1;
   localparam int B_CAP  = 0;

   typedef enum logic [2:0] {
      MODE_RELOAD  = 3'd0,
      MODE_CAPTURE = 3'd1,
      MODE_UPDOWN  = 3'd2,
      MODE_BAUD    = 3'd3,
      MODE_CLKOUT  = 3'd4
   } mode_e;
endpackage

// File: rtl/crt_edge_det.sv
module crt_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("crt_edge_det: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= 1'b0;
      else        q[0] <= pin;
   end

   generate
      for (genvar gi = 1; gi < STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[gi] <= 1'b0;
            else        q[gi] <= q[gi-1];
         end
      end
   endgenerate

   assign level = q[STAGES-2];
   assign fall  = q[STAGES-1] & ~q[STAGES-2];
endmodule

// File: rtl/crt_mode_dec.sv
module crt_mode_dec
   import crt_pkg::*;
#(
   parameter int CTL_W = 8
) (
   input  logic [CTL_W-1:0] ctl,
   input  logic             updown_en,
   input  logic             clkout_en,
   output mode_e            mode
);
   always_comb begin
      if (ctl[B_RXS] | ctl[B_TXS])        mode = MODE_BAUD;
      else if (clkout_en & ~ctl[B_SRC])   mode = MODE_CLKOUT;
      else if (ctl[B_CAP])                mode = MODE_CAPTURE;
      else if (updown_en)                 mode = MODE_UPDOWN;
      else                                mode = MODE_RELOAD;
   end
endmodule

// File: rtl/crt_core.sv
module crt_core
   import crt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             ext_evt,
   input  logic             dir_up,
   input  mode_e            mode,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             rc_we,
   input  logic [CNT_W-1:0] rc_wdata,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] rc,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             up_ovf, dn_unf;
   logic [CNT_W-1:0] cnt_nxt, rc_nxt;

   always_comb begin
      up_ovf  = step & dir_up & (count == MAXV);
      dn_unf  = step & ~dir_up & (count == rc);
      cnt_nxt = count;
      if (cnt_we)                                cnt_nxt = cnt_wdata;
      else if (ext_evt && mode == MODE_RELOAD)   cnt_nxt = rc;
      else if (up_ovf)                           cnt_nxt = (mode == MODE_CAPTURE) ? '0 : rc;
      else if (dn_unf)                           cnt_nxt = MAXV;
      else if (step)                             cnt_nxt = dir_up ? count + ONE : count - ONE;

      rc_nxt = rc;
      if (ext_evt && mode == MODE_CAPTURE)       rc_nxt = count;
      else if (rc_we)                            rc_nxt = rc_wdata;
   end

   assign ovf_evt = up_ovf | dn_unf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         rc    <= '0;
      end else begin
         count <= cnt_nxt;
         rc    <= rc_nxt;
      end
   end
endmodule

// File: rtl/crt_timer.sv
module crt_timer
   import crt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CTL_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cnt_pin,
   input  logic             stb_pin,
   input  logic             updown_en,
   input  logic             clkout_en,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             rc_we,
   input  logic [CNT_W-1:0] rc_wdata,
   output logic [CTL_W-1:0] ctl_q,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] rc_q,
   output logic             ovf_flag,
   output logic             ext_flag,
   output logic             irq,
   output logic             rx_baud,
   output logic             tx_baud,
   output logic             clk_out
);
   generate
      if (CTL_W != 8) begin : g_bad_ctl
         $error("crt_timer: CTL_W must be 8");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("crt_timer: CNT_W must be at least 4");
      end
   endgenerate

   mode_e            mode;
   logic             cnt_lvl, cnt_fall, stb_lvl, stb_fall;
   logic             step, ext_evt, dir_up, ovf_evt, tf_set;
   logic [CTL_W-1:0] ctl_nxt;

   crt_edge_det #(.STAGES(SYNC_STAGES)) u_cnt_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall)
   );

   crt_edge_det #(.STAGES(SYNC_STAGES)) u_stb_edge (
      .clk(clk), .rst_n(rst_n), .pin(stb_pin), .level(stb_lvl), .fall(stb_fall)
   );

   crt_mode_dec #(.CTL_W(CTL_W)) u_mode (
      .ctl(ctl_q), .updown_en(updown_en), .clkout_en(clkout_en), .mode(mode)
   );

   assign step    = ctl_q[B_RUN] & (ctl_q[B_SRC] ? cnt_fall : tick_en);
   assign ext_evt = ctl_q[B_EXEN] & stb_fall;
   assign dir_up  = (mode != MODE_UPDOWN) | stb_lvl;

   crt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .ext_evt(ext_evt), .dir_up(dir_up),
      .mode(mode), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rc_we(rc_we),
      .rc_wdata(rc_wdata), .count(count_q), .rc(rc_q), .ovf_evt(ovf_evt)
   );

   assign tf_set = ovf_evt & (mode != MODE_BAUD) & (mode != MODE_CLKOUT);

   always_comb begin
      ctl_nxt = ctl_we ? ctl_wdata : ctl_q;
      if (tf_set)  ctl_nxt[B_OVF] = 1'b1;
      if (ext_evt) ctl_nxt[B_EXT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         rx_baud <= 1'b0;
         tx_baud <= 1'b0;
         clk_out <= 1'b0;
      end else begin
         ctl_q   <= ctl_nxt;
         rx_baud <= ovf_evt & (mode == MODE_BAUD) & ctl_q[B_RXS];
         tx_baud <= ovf_evt & (mode == MODE_BAUD) & ctl_q[B_TXS];
         clk_out <= clk_out ^ (ovf_evt & (mode == MODE_CLKOUT));
      end
   end

   assign ovf_flag = ctl_q[B_OVF];
   assign ext_flag = ctl_q[B_EXT];
   assign irq      = ctl_q[B_OVF] | (ctl_q[B_EXT] & (mode != MODE_UPDOWN));
endmodule

// File: rtl/crt_timer_chk.sv
module crt_timer_chk #(
   parameter int CNT_W = 16,
   parameter int CTL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic             cnt_we,
   input logic [CTL_W-1:0] ctl_q,
   input logic [CNT_W-1:0] count_q,
   input logic             irq,
   input logic             rx_baud,
   input logic             tx_baud
);
   // R1: clean state right after reset release
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctl_q == '0 && count_q == '0 && !irq));

   // R2: stopped counter with strobe disabled and no write holds its value
   a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[2] && !ctl_q[3] && !cnt_we) |=> $stable(count_q));

   // R6: baud selection keeps the overflow flag low
   a_r6_no_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && (ctl_q[5] || ctl_q[4]) && !ctl_q[7]) |=> !ctl_q[7]);

   // R6: baud pulses only follow a cycle with their select set
   a_r6_rx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      rx_baud |-> $past(ctl_q[5]));
   a_r6_tx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      tx_baud |-> $past(ctl_q[4]));

   // R8: a set overflow flag always requests an interrupt
   a_r8_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[7] |-> irq);

   // R9: flags fall only after a control write
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q[7]) |-> $past(ctl_we));
   a_r9_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q[6]) |-> $past(ctl_we));
endmodule

bind crt_timer crt_timer_chk #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cnt_we(cnt_we), .ctl_q(ctl_q),
   .count_q(count_q), .irq(irq), .rx_baud(rx_baud), .tx_baud(tx_baud)
);

// File: tb/crt_timer_bench.sv
module crt_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, cnt_pin = 1'b1, stb_pin = 1'b1;
   logic        updown_en = 1'b0, clkout_en = 1'b0;
   logic        ctl_we = 1'b0, cnt_we = 1'b0, rc_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [15:0] cnt_wdata = '0, rc_wdata = '0;
   logic [7:0]  ctl_q;
   logic [15:0] count_q, rc_q;
   logic        ovf_flag, ext_flag, irq, rx_baud, tx_baud, clk_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   crt_timer u_crt_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin), .stb_pin(stb_pin),
      .updown_en(updown_en), .clkout_en(clkout_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rc_we(rc_we), .rc_wdata(rc_wdata),
      .ctl_q(ctl_q), .count_q(count_q), .rc_q(rc_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
      .irq(irq), .rx_baud(rx_baud), .tx_baud(tx_baud), .clk_out(clk_out)
   );

   typedef struct packed {
      logic [7:0]  ctl;
      logic        dcen;
      logic        lvl;
      logic [15:0] rc;
      logic [15:0] cnt;
      logic [7:0]  ticks;
      logic [15:0] exp;
      logic        tf;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'h04, 1'b0, 1'b1, 16'h1234, 16'hFFFE, 8'd1, 16'hFFFF, 1'b0},  // R3 plain count
      '{8'h04, 1'b0, 1'b1, 16'h1234, 16'hFFFE, 8'd2, 16'h1234, 1'b1},  // R3 reload
      '{8'h04, 1'b0, 1'b1, 16'h1234, 16'hFFFE, 8'd5, 16'h1237, 1'b1},  // R3 past reload
      '{8'h05, 1'b0, 1'b1, 16'h1234, 16'hFFFF, 8'd1, 16'h0000, 1'b1},  // R4 wrap to 0
      '{8'h34, 1'b0, 1'b1, 16'hFFF0, 16'hFFFF, 8'd3, 16'hFFF2, 1'b0},  // R6 no flag
      '{8'h00, 1'b0, 1'b1, 16'h1234, 16'h0100, 8'd4, 16'h0100, 1'b0},  // R2 stopped
      '{8'h04, 1'b1, 1'b0, 16'h0010, 16'h0012, 8'd3, 16'hFFFF, 1'b1},  // R7 underflow
      '{8'h04, 1'b1, 1'b1, 16'h0010, 16'hFFFF, 8'd1, 16'h0010, 1'b1}   // R7 up reload
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_cnt(input logic [15:0] v);
      cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic wr_rc(input logic [15:0] v);
      rc_we = 1'b1; rc_wdata = v;
      @(negedge clk);
      rc_we = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic strobe_fall();
      stb_pin = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic strobe_high();
      stb_pin = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctl", ctl_q, 8'h00);
      chk("R1 count", count_q, 16'h0000);
      chk("R1 rc", rc_q, 16'h0000);
      chk("R1 outs", {irq, rx_baud, tx_baud, clk_out}, 4'b0000);

      for (int i = 0; i < NV; i++) begin
         updown_en = VECS[i].dcen;
         stb_pin   = VECS[i].lvl;
         repeat (3) @(negedge clk);
         wr_rc(VECS[i].rc);
         wr_cnt(VECS[i].cnt);
         wr_ctl(VECS[i].ctl);
         run_ticks(int'(VECS[i].ticks));
         chk($sformatf("R3/R4/R6/R7 vec%0d count", i), count_q, VECS[i].exp);
         chk($sformatf("R3/R4/R6/R7 vec%0d ovf", i), ovf_flag, VECS[i].tf);
      end
      updown_en = 1'b0;

      // R4 capture on strobe edge
      wr_ctl(8'h00); strobe_high();
      wr_rc(16'h0000); wr_cnt(16'h5A5A); wr_ctl(8'h0D);
      strobe_fall();
      chk("R4 capture rc", rc_q, 16'h5A5A);
      chk("R4 capture flag", {ext_flag, irq}, 2'b11);

      // R4 strobe ignored with enable off
      wr_ctl(8'h05); strobe_high(); wr_cnt(16'h1111);
      strobe_fall();
      chk("R4 ignored rc", rc_q, 16'h5A5A);
      chk("R4 ignored flag", {ext_flag, irq}, 2'b00);

      // R5 reload on strobe edge
      strobe_high();
      wr_rc(16'h4321); wr_cnt(16'h0007); wr_ctl(8'h0C);
      strobe_fall();
      chk("R5 strobe reload", count_q, 16'h4321);
      chk("R5 strobe flag", ext_flag, 1'b1);

      // R8 strobe flag masked in up/down mode
      wr_ctl(8'h00); strobe_high(); updown_en = 1'b1;
      wr_cnt(16'h0042); wr_ctl(8'h0C);
      strobe_fall();
      chk("R7 no reload in up/down", count_q, 16'h0042);
      chk("R8 masked irq", {ext_flag, irq}, 2'b10);
      updown_en = 1'b0;
      #1;
      chk("R8 unmasked irq", irq, 1'b1);
      @(negedge clk);

      // R2 external event counting
      wr_ctl(8'h00); wr_cnt(16'h0000); wr_ctl(8'h06);
      for (int k = 0; k < 3; k++) begin
         cnt_pin = 1'b0; repeat (2) @(negedge clk);
         cnt_pin = 1'b1; repeat (2) @(negedge clk);
      end
      tick_en = 1'b1; repeat (2) @(negedge clk); tick_en = 1'b0;
      chk("R2 external count", count_q, 16'h0003);

      // R6 receive and transmit pulses
      wr_rc(16'hFFFE); wr_cnt(16'hFFFF); wr_ctl(8'h24);
      run_ticks(1);
      chk("R6 rx pulse", {rx_baud, tx_baud, ovf_flag}, 3'b100);
      chk("R6 reload", count_q, 16'hFFFE);
      @(negedge clk);
      chk("R6 rx one cycle", rx_baud, 1'b0);
      wr_cnt(16'hFFFF); wr_ctl(8'h14);
      run_ticks(1);
      chk("R6 tx pulse", {rx_baud, tx_baud, ovf_flag}, 3'b010);

      // R9 same-cycle collisions
      wr_rc(16'h0000); wr_cnt(16'hFFFF); wr_ctl(8'h04);
      tick_en = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'h04;
      @(negedge clk);
      tick_en = 1'b0; ctl_we = 1'b0;
      chk("R9 set beats clear", ovf_flag, 1'b1);
      chk("R9 count reloaded", count_q, 16'h0000);
      tick_en = 1'b1; cnt_we = 1'b1; cnt_wdata = 16'h0100;
      @(negedge clk);
      tick_en = 1'b0; cnt_we = 1'b0;
      chk("R9 write beats step", count_q, 16'h0100);
      @(negedge clk);
      chk("R9 flag sticky", ovf_flag, 1'b1);

      // R10 clock output
      clkout_en = 1'b1;
      wr_ctl(8'h00); wr_rc(16'hFFFF); wr_cnt(16'hFFFF); wr_ctl(8'h04);
      run_ticks(1);
      chk("R10 toggle high", {clk_out, ovf_flag}, 2'b10);
      run_ticks(1);
      chk("R10 toggle low", {clk_out, ovf_flag}, 2'b00);
      clkout_en = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule